// File: doc/BRIEF.md
# Keyboard Controller Register Block

This block is the register front end of a keyboard port as polling software sees it. A processor reaches it through a one-cycle load/store bus with a single address bit. The control address reads back a status byte and takes command bytes when written. The data address returns the last received scancode when read, and takes a command argument when written. On the device side, a receiver that has already decoded the serial line offers scancode bytes with a valid strobe. The block also drives a small LED output.

Software polls the output-full status bit and then loads the data byte, and that load empties the buffer. Commands enable the keyboard, run a self test, or arm a two-step LED update in which the next data write supplies the LED pattern. The block keeps a small amount of state between accesses: the enable flag, a pending LED argument, the last-write kind and the sticky flags. That state is why it behaves as a command machine and not as a plain register file.

Top module: `kbc_regblock`

## Requirements
- R1: After synchronous active-low reset the status byte reads 0x00, the data byte reads 0x00, the LED output is 0 and the keyboard is disabled.
- R2: While the keyboard is disabled, a scancode offered on kb_valid changes neither the data byte nor any status bit.
- R3: Writing command 0xAE to the control address enables the keyboard. An accepted scancode is then stored in the data byte and sets output-full (status bit 0).
- R4: A bus read of the data address clears output-full from the next cycle on. A bus read of the control address leaves output-full unchanged.
- R5: A scancode that arrives while output-full is set is dropped, and the data byte keeps its old value. The drop sets the timeout flag (status bit 6), which stays set until a bus read of the control address, and that read still returns it as 1.
- R6: After command 0xED, the next data-address write raises input-full (status bit 1) for exactly one cycle. In the cycle after that, the LED output takes bits [2:0] of the written byte.
- R7: A data-address write with no LED command pending leaves the LED output unchanged.
- R8: Status bit 3 is 1 after a write to the control address and 0 after a write to the data address.
- R9: Command 0xAA loads 0x55 into the data byte and sets output-full and the system flag (status bit 2).
- R10: Bus address 1 reads status and writes commands; bus address 0 reads and writes data. Status bits 7, 5 and 4 always read 0.
- R11: If a scancode arrives in the same cycle as command 0xAA, the self-test byte is kept, the scancode is dropped and the timeout flag is set.
- R12: Any command byte other than 0xED cancels a pending LED command, and command bytes other than 0xAA, 0xAE and 0xED affect only status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 1 | 1 = status/command, 0 = data |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Load data, combinational from bus_addr |
| kb_valid | input | 1 | Scancode offered this cycle |
| kb_data | input | 8 | Scancode byte |
| led | output | LED_W | LED pattern |

## Verification
The assertions assume that at most one bus access happens per cycle, and that kb_valid is a single-cycle strobe whose byte is meaningful only while the strobe is high. They do not assume anything about how commands are ordered. The bench drives each access and each scancode for exactly one cycle, on the falling edge, and drops the strobes one nanosecond after the rising edge. The only overlap it creates on purpose is a self-test command in the same cycle as a scancode, which is the case that R11 defines.

// File: rtl/kbc_pkg.sv
// Shared constants and the status layout for the keyboard register block.
// Assumes an 8-bit bus and a single address bit for the register select.
package kbc_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_SELFTEST = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_ENABLE   = 8'hAE;
    localparam logic [BYTE_W-1:0] CMD_SET_LED  = 8'hED;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    // Status byte, MSB first; software decodes these positions.
    typedef struct packed {
        logic perr;
        logic tmo;
        logic aux;
        logic lock;
        logic last_cmd;
        logic sysf;
        logic ibf;
        logic obf;
    } kbc_status_t;
endpackage

// File: rtl/kbc_cmd_ctl.sv
// Command decoder: holds enable, pending-LED, last-write-kind and system flag.
// Assumes cmd_wr and data_wr are never high in the same cycle.
module kbc_cmd_ctl
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              kb_en,
    output logic              last_cmd,
    output logic              sysf,
    output logic              st_go,
    output logic              arg_go
);
    logic led_wait;

    // Single-cycle strobes that the output buffer and the LED latch act on.
    always_comb begin
        st_go  = cmd_wr && (wdata == CMD_SELFTEST);
        arg_go = data_wr && led_wait;
    end

    // Track command state across bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kb_en    <= 1'b0;
            led_wait <= 1'b0;
            last_cmd <= 1'b0;
            sysf     <= 1'b0;
        end else if (cmd_wr) begin
            last_cmd <= 1'b1;
            led_wait <= (wdata == CMD_SET_LED);
            if (wdata == CMD_ENABLE)   kb_en <= 1'b1;
            if (wdata == CMD_SELFTEST) sysf  <= 1'b1;
        end else if (data_wr) begin
            last_cmd <= 1'b0;
            led_wait <= 1'b0;
        end
    end

    // R8
    cmd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> last_cmd);
    // R8
    data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !last_cmd);
    // R12
    cancel_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata != CMD_SET_LED) ##1 data_wr |-> !arg_go);
    // R9
    sysf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sysf |=> sysf);
endmodule

// File: rtl/kbc_obuf.sv
// Output buffer: data byte, output-full flag and sticky timeout flag.
// Assumes rd_data and rd_status are never high together, nor with st_go.
module kbc_obuf
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SELFTEST_BYTE = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_valid,
    input  logic [BYTE_W-1:0] kb_data,
    input  logic              kb_en,
    input  logic              st_go,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [BYTE_W-1:0] data_q,
    output logic              obf,
    output logic              tmo
);
    logic offered;
    logic drop;

    // Classify the incoming scancode for this cycle.
    always_comb begin
        offered = kb_valid && kb_en;
        drop    = offered && (obf || st_go);
    end

    // Load, hold or release the buffered byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            obf    <= 1'b0;
        end else if (st_go) begin
            data_q <= SELFTEST_BYTE;
            obf    <= 1'b1;
        end else if (offered && !obf) begin
            data_q <= kb_data;
            obf    <= 1'b1;
        end else if (rd_data) begin
            obf    <= 1'b0;
        end
    end

    // Sticky timeout: set on a dropped byte, cleared by a status load.
    always_ff @(posedge clk) begin
        if (!rst_n)         tmo <= 1'b0;
        else if (drop)      tmo <= 1'b1;
        else if (rd_status) tmo <= 1'b0;
    end

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && obf) |=> !obf);
    // R4
    status_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && obf) |=> obf);
    // R5
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offered && obf && !st_go) |=> ($stable(data_q) && tmo));
    // R2
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && !kb_en && !st_go) |=> $stable(data_q));
    // R11
    selftest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_go |=> (data_q == SELFTEST_BYTE && obf));
endmodule

// File: rtl/kbc_led_latch.sv
// LED argument latch: captures the argument, shows input-full for one
// cycle, then updates the LED output. Assumes arg_go is a one-cycle strobe.
module kbc_led_latch #(
    parameter int LED_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arg_go,
    input  logic [LED_W-1:0] arg,
    output logic             ibf,
    output logic [LED_W-1:0] led
);
    logic [LED_W-1:0] arg_q;

    // Two-step update: capture with input-full, then publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q <= '0;
            ibf   <= 1'b0;
            led   <= '0;
        end else begin
            ibf <= arg_go;
            if (arg_go) arg_q <= arg;
            if (ibf)    led   <= arg_q;
        end
    end

    // R6
    ibf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ibf |=> !ibf);
    // R6
    led_after_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led) |-> $past(ibf));
    // R6
    led_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arg_go ##1 1'b1 |=> (led == $past(arg, 2)));
endmodule

// File: rtl/kbc_regblock.sv
// Keyboard controller register block: decodes bus accesses into command,
// data and status actions, and assembles the status byte.
// Assumes at most one bus access per cycle; read data is combinational.
module kbc_regblock
    import kbc_pkg::*;
#(
    parameter int                LED_W         = 3,
    parameter logic [BYTE_W-1:0] SELFTEST_BYTE = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              kb_valid,
    input  logic [BYTE_W-1:0] kb_data,
    output logic [LED_W-1:0]  led
);
    logic cmd_wr, data_wr, rd_data, rd_status;
    logic kb_en, last_cmd, sysf, st_go, arg_go;
    logic obf, tmo, ibf;
    logic [BYTE_W-1:0] data_q;
    kbc_status_t status;

    // Decode the single bus access into one of four actions.
    always_comb begin
        cmd_wr    = bus_sel &&  bus_we && (bus_addr == ADDR_CTRL);
        data_wr   = bus_sel &&  bus_we && (bus_addr == ADDR_DATA);
        rd_status = bus_sel && !bus_we && (bus_addr == ADDR_CTRL);
        rd_data   = bus_sel && !bus_we && (bus_addr == ADDR_DATA);
    end

    // Assemble status; unused positions read zero.
    always_comb begin
        status          = '0;
        status.tmo      = tmo;
        status.last_cmd = last_cmd;
        status.sysf     = sysf;
        status.ibf      = ibf;
        status.obf      = obf;
        bus_rdata       = (bus_addr == ADDR_CTRL) ? status : data_q;
    end

    kbc_cmd_ctl u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
        .wdata(bus_wdata), .kb_en(kb_en), .last_cmd(last_cmd), .sysf(sysf),
        .st_go(st_go), .arg_go(arg_go)
    );

    kbc_obuf #(.SELFTEST_BYTE(SELFTEST_BYTE)) u_obuf (
        .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_data(kb_data),
        .kb_en(kb_en), .st_go(st_go), .rd_data(rd_data),
        .rd_status(rd_status), .data_q(data_q), .obf(obf), .tmo(tmo)
    );

    kbc_led_latch #(.LED_W(LED_W)) u_led (
        .clk(clk), .rst_n(rst_n), .arg_go(arg_go),
        .arg(bus_wdata[LED_W-1:0]), .ibf(ibf), .led(led)
    );

    // R10
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[7] == 1'b0 &&
                                     bus_rdata[5:4] == 2'b00));
    // R7
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ibf |=> $stable(led));
endmodule

// File: tb/sim_kbc_regblock.sv
`timescale 1ns/1ps
module sim_kbc_regblock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       kb_valid = 1'b0;
    logic [7:0] kb_data = 8'h00;
    logic [2:0] led;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;
    logic [7:0] v;

    always #2.5 clk = ~clk;

    kbc_regblock u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kb_valid(kb_valid), .kb_data(kb_data), .led(led)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic kb_send(input logic [7:0] d);
        @(negedge clk);
        kb_valid = 1'b1; kb_data = d;
        @(posedge clk);
        #1 kb_valid = 1'b0;
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 R10: reset state through both addresses
        rd(1'b1, v); chk("R1 status", v, 8'h00);
        rd(1'b0, v); chk("R1 data", v, 8'h00);
        chk("R1 led", {5'b0, led}, 8'h00);
        // R2: disabled keyboard ignores scancodes
        kb_send(8'h1C);
        rd(1'b1, v); chk("R2 status", v, 8'h00);
        rd(1'b0, v); chk("R2 data", v, 8'h00);
        // R12 R8: unknown command only sets last-write bit
        wr(1'b1, 8'h12);
        peek(1'b1, v); chk("R12 status", v, 8'h08);
        chk("R12 led", {5'b0, led}, 8'h00);
        // R3: enable then sweep every scancode value
        wr(1'b1, 8'hAE);
        for (int i = 0; i < 256; i++) begin
            kb_send(8'(i));
            rd(1'b1, v); chk("R3 R4 status full", v, 8'h09);
            rd(1'b0, v); chk("R3 data", v, 8'(i));
            rd(1'b1, v); chk("R4 status empty", v, 8'h08);
        end
        // R5: overrun drops byte and sets sticky timeout
        kb_send(8'h11);
        kb_send(8'h22);
        rd(1'b1, v); chk("R5 timeout shown", v, 8'h49);
        rd(1'b1, v); chk("R5 timeout cleared", v, 8'h09);
        rd(1'b0, v); chk("R5 data kept", v, 8'h11);
        rd(1'b1, v); chk("R5 empty", v, 8'h08);
        // R6 R8: sweep all LED patterns with varied upper bits
        for (int i = 0; i < 8; i++) begin
            logic [7:0] w;
            logic [2:0] prev;
            w = 8'(i * 41);
            prev = led;
            wr(1'b1, 8'hED);
            peek(1'b1, v); chk("R8 after command", v, 8'h08);
            wr(1'b0, w);
            peek(1'b1, v); chk("R6 input-full", v, 8'h02);
            chk("R6 led not yet", {5'b0, led}, {5'b0, prev});
            @(posedge clk); #1;
            peek(1'b1, v); chk("R6 input-full gone", v, 8'h00);
            chk("R6 led", {5'b0, led}, {5'b0, w[2:0]});
        end
        // R7: data write without pending LED command
        wr(1'b0, 8'h05);
        @(posedge clk); #1;
        chk("R7 led", {5'b0, led}, 8'h07);
        peek(1'b1, v); chk("R7 status", v, 8'h00);
        // R12: intervening command cancels LED command
        wr(1'b1, 8'hED);
        wr(1'b1, 8'h12);
        wr(1'b0, 8'h02);
        @(posedge clk); #1;
        chk("R12 led kept", {5'b0, led}, 8'h07);
        // R9: self test
        wr(1'b1, 8'hAA);
        peek(1'b1, v); chk("R9 status", v, 8'h0D);
        rd(1'b0, v); chk("R9 data", v, 8'h55);
        rd(1'b1, v); chk("R9 status after read", v, 8'h0C);
        // R11: scancode coincident with self test
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'hAA;
        kb_valid = 1'b1; kb_data = 8'h33;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0; kb_valid = 1'b0;
        rd(1'b1, v); chk("R11 status", v, 8'h4D);
        rd(1'b0, v); chk("R11 data", v, 8'h55);
        rd(1'b1, v); chk("R11 after", v, 8'h0C);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule